// File: doc/BRIEF.md
# Two-Source Vector Swizzle Interleaver

This block rebuilds a vector array by choosing, for every destination sub-element, one sub-element out of two source vector arrays. A per-vector selector word supplies one 3-bit field per destination lane. The low two bits of a field give the lane inside the current source sub-vector. The top bit gives the source array. The destination and source sub-vector lengths are set separately, so a single pass can widen, narrow, repeat or interleave sub-elements.

The block also decodes a 32-bit instruction word into one of six swizzle variants. The variant chooses the operating mode:

- Two-source register forms take the source from the field's top bit.
- Single-source register forms always read the first array.
- Immediate forms take four 2-bit lane fields from the instruction itself.

An operation starts with a one-cycle `start` pulse and then handles one vector per clock. It stops at the first vector that breaks a rule. It ends with a one-cycle `done` pulse, and `illegal` tells whether the run finished normally or trapped. The instruction, configuration and source arrays must stay stable while `busy` is high.

Top module: `vec_swizzle_interleaver`

## Requirements
- R1: In the two-source variants (code 0 integer, code 1 floating point), a selector field with bit 2 set takes its lane from `src_a_flat`, and a field with bit 2 clear takes it from `src_b_flat`. Lane i of vector v uses selector bits [3i+2:3i] of selector word v.
- R2: For vector v and destination lane i < `dst_sub`, the element read is source element v*`src_sub` + field[1:0]. It is written to destination element v*`dst_sub` + i. Element k sits at bits [8k+7:8k] of each flat array. Destination elements that are not written keep their value.
- R3: In the register variants, a nonzero selector bit at position 3*`dst_sub` or above traps that vector. On a trap, `illegal` is set together with `done`, and that vector and all later vectors are not written. Earlier vectors stay written.
- R4: A lane field whose bits [1:0] are `src_sub` or greater traps the vector in the same way as R3.
- R5: When insn[14:12] = 000, the `variant` output takes the value of insn[26:25]: 0 integer two-source, 1 floating-point two-source, 2 integer single-source, 3 floating-point single-source. `variant` is captured when a start is accepted.
- R6: insn[14:12] = 001 gives variant 4 (integer immediate), and 010 gives variant 5 (floating-point immediate). Any other value gives variant 7, which finishes with `illegal` set and no writes.
- R7: In variants 2 and 3, selector bit 2 is ignored and every lane reads `src_a_flat`.
- R8: In variants 4 and 5, the selector input is ignored. Lane i uses the lane number in insn[21+2i:20+2i] (x at 21:20, y at 23:22, z at 25:24, w at 27:26) and reads `src_a_flat`.
- R9: A start that is accepted while the block is idle sets `busy` on the next cycle. The block then handles one vector per clock, and `done` is high for exactly one cycle with `busy` low, in the cycle after the last vector. With `vl` = 0, `done` follows one busy cycle and nothing is written. A start that arrives while `busy` is high is ignored.
- R10: Any of the following finishes the operation with `illegal` set and no writes: `vl` above MAX_VL, or a `dst_sub` or `src_sub` that is zero or above MAX_SUB.
- R11: After reset, every destination element is zero, `busy`, `done` and `illegal` are low, and `variant` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| insn | input | 32 | Instruction word for variant decode and immediate lanes |
| vl | input | 3 | Number of vectors to process |
| dst_sub | input | 3 | Destination sub-vector length |
| src_sub | input | 3 | Source sub-vector length |
| src_a_flat | input | 128 | First source array, 16 elements of 8 bits |
| src_b_flat | input | 128 | Second source array, 16 elements of 8 bits |
| sel_flat | input | 48 | Four selector words of 12 bits |
| dst_flat | output | 128 | Destination array, 16 elements of 8 bits |
| variant | output | 3 | Decoded variant code |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last operation trapped or was undecodable |

## Verification
The assertions check the following on every cycle:

- The completion pulse is a single cycle and never overlaps `busy`.
- `illegal` only rises together with `done`.
- An invalid variant always ends as illegal.
- The destination never changes while the block is idle.
- The vector counter stays in range.

Only the bench's scenarios can show the data behaviour: which source and lane each destination element came from, how differing sub-vector lengths move the read and write indices, that a trap leaves earlier vectors in place, and that immediate and single-source forms ignore the selector bits they are meant to ignore. For this, a behavioural model runs in step with the design and is compared on every clock.

// File: rtl/swz_pkg.sv
package swz_pkg;
  typedef enum logic [2:0] {
    VAR_INT2 = 3'd0,
    VAR_FP2  = 3'd1,
    VAR_INT1 = 3'd2,
    VAR_FP1  = 3'd3,
    VAR_INTI = 3'd4,
    VAR_FPI  = 3'd5,
    VAR_BAD  = 3'd7
  } swz_var_e;
endpackage

// File: rtl/swz_decode.sv
module swz_decode
  import swz_pkg::*;
(
  input  logic [31:0] insn,
  output swz_var_e    var_o
);
  always_comb begin
    unique case (insn[14:12])
      3'b000: begin
        unique case (insn[26:25])
          2'b00:   var_o = VAR_INT2;
          2'b01:   var_o = VAR_FP2;
          2'b10:   var_o = VAR_INT1;
          default: var_o = VAR_FP1;
        endcase
      end
      3'b001:  var_o = VAR_INTI;
      3'b010:  var_o = VAR_FPI;
      default: var_o = VAR_BAD;
    endcase
  end
endmodule

// File: rtl/swz_lane_pick.sv
module swz_lane_pick #(
  parameter int ELEM_W  = 8,
  parameter int MAX_VL  = 4,
  parameter int MAX_SUB = 4,
  localparam int NUM_EL = MAX_VL * MAX_SUB,
  localparam int SEL_W  = 3 * MAX_SUB,
  localparam int VL_W   = $clog2(MAX_VL + 1),
  localparam int SUB_W  = $clog2(MAX_SUB + 1),
  localparam int IDX_W  = VL_W + SUB_W
) (
  input  logic [VL_W-1:0]          vidx,
  input  logic [SUB_W-1:0]         dst_sub,
  input  logic [SUB_W-1:0]         src_sub,
  input  logic                     use_imm,
  input  logic                     one_src,
  input  logic [7:0]               imm,
  input  logic [SEL_W-1:0]         sel_word,
  input  logic [NUM_EL*ELEM_W-1:0] src_a_flat,
  input  logic [NUM_EL*ELEM_W-1:0] src_b_flat,
  output logic [ELEM_W-1:0]        lane_val [MAX_SUB],
  output logic [MAX_SUB-1:0]       lane_bad
);
  logic [ELEM_W-1:0] a_arr [NUM_EL];
  logic [ELEM_W-1:0] b_arr [NUM_EL];

  always_comb begin
    for (int k = 0; k < NUM_EL; k++) begin
      a_arr[k] = src_a_flat[k*ELEM_W +: ELEM_W];
      b_arr[k] = src_b_flat[k*ELEM_W +: ELEM_W];
    end
  end

  for (genvar i = 0; i < MAX_SUB; i++) begin : g_lane
    logic [2:0]       fld;
    logic             imm_gap;
    logic             from_a;
    logic [IDX_W-1:0] ridx;

    // Immediate selectors only carry four lane fields.
    if (i < 4) begin : g_imm
      assign fld     = use_imm ? {1'b1, imm[2*i +: 2]} : sel_word[3*i +: 3];
      assign imm_gap = 1'b0;
    end else begin : g_noimm
      assign fld     = sel_word[3*i +: 3];
      assign imm_gap = use_imm;
    end

    assign from_a = one_src | fld[2];
    assign ridx   = IDX_W'(vidx) * IDX_W'(src_sub) + IDX_W'(fld[1:0]);

    always_comb begin
      lane_bad[i] = (SUB_W'(i) < dst_sub) &&
                    ((SUB_W'(fld[1:0]) >= src_sub) || imm_gap ||
                     (int'(ridx) >= NUM_EL));
      lane_val[i] = '0;
      if (int'(ridx) < NUM_EL) begin
        lane_val[i] = from_a ? a_arr[ridx] : b_arr[ridx];
      end
    end
  end
endmodule

// File: rtl/vec_swizzle_interleaver.sv
module vec_swizzle_interleaver
  import swz_pkg::*;
#(
  parameter int ELEM_W  = 8,
  parameter int MAX_VL  = 4,
  parameter int MAX_SUB = 4,
  localparam int NUM_EL = MAX_VL * MAX_SUB,
  localparam int SEL_W  = 3 * MAX_SUB,
  localparam int VL_W   = $clog2(MAX_VL + 1),
  localparam int SUB_W  = $clog2(MAX_SUB + 1),
  localparam int IDX_W  = VL_W + SUB_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [31:0]              insn,
  input  logic [VL_W-1:0]          vl,
  input  logic [SUB_W-1:0]         dst_sub,
  input  logic [SUB_W-1:0]         src_sub,
  input  logic [NUM_EL*ELEM_W-1:0] src_a_flat,
  input  logic [NUM_EL*ELEM_W-1:0] src_b_flat,
  input  logic [MAX_VL*SEL_W-1:0]  sel_flat,
  output logic [NUM_EL*ELEM_W-1:0] dst_flat,
  output logic [2:0]               variant,
  output logic                     busy,
  output logic                     done,
  output logic                     illegal
);
  // rst_n is expected to leave reset synchronously to clk (external synchronizer).
  swz_var_e          dec_var, var_q, var_d;
  logic              busy_q, busy_d, done_q, done_d, ill_q, ill_d;
  logic [VL_W-1:0]   vidx_q, vidx_d;
  logic [ELEM_W-1:0] dst_q [NUM_EL];
  logic [ELEM_W-1:0] dst_d [NUM_EL];
  logic              wr_en;

  logic              use_imm, one_src, cfg_bad, upper_bad, vec_bad, last_vec;
  logic [SEL_W-1:0]  sel_word;
  logic [ELEM_W-1:0] lane_val [MAX_SUB];
  logic [MAX_SUB-1:0] lane_bad;

  swz_decode u_dec (.insn(insn), .var_o(dec_var));

  assign use_imm = (var_q == VAR_INTI) || (var_q == VAR_FPI);
  assign one_src = (var_q == VAR_INT1) || (var_q == VAR_FP1);

  always_comb begin
    sel_word = '0;
    for (int v = 0; v < MAX_VL; v++) begin
      if (VL_W'(v) == vidx_q) sel_word = sel_flat[v*SEL_W +: SEL_W];
    end
  end

  swz_lane_pick #(.ELEM_W(ELEM_W), .MAX_VL(MAX_VL), .MAX_SUB(MAX_SUB)) u_pick (
    .vidx(vidx_q), .dst_sub(dst_sub), .src_sub(src_sub),
    .use_imm(use_imm), .one_src(one_src), .imm(insn[27:20]),
    .sel_word(sel_word), .src_a_flat(src_a_flat), .src_b_flat(src_b_flat),
    .lane_val(lane_val), .lane_bad(lane_bad)
  );

  always_comb begin
    upper_bad = 1'b0;
    for (int b = 0; b < SEL_W; b++) begin
      if (!use_imm && (b >= 3 * int'(dst_sub)) && sel_word[b]) upper_bad = 1'b1;
    end
  end

  assign cfg_bad  = (var_q == VAR_BAD) || (int'(vl) > MAX_VL) ||
                    (dst_sub == '0) || (int'(dst_sub) > MAX_SUB) ||
                    (src_sub == '0) || (int'(src_sub) > MAX_SUB);
  assign vec_bad  = upper_bad || (|lane_bad);
  assign last_vec = VL_W'(vidx_q + VL_W'(1)) >= vl;

  // Next-state process
  always_comb begin
    busy_d = busy_q;
    vidx_d = vidx_q;
    ill_d  = ill_q;
    var_d  = var_q;
    done_d = 1'b0;
    wr_en  = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        vidx_d = '0;
        ill_d  = 1'b0;
        var_d  = dec_var;
      end
    end else if (cfg_bad || (vl != '0 && vec_bad)) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      ill_d  = 1'b1;
    end else if (vl == '0) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else begin
      wr_en  = 1'b1;
      vidx_d = VL_W'(vidx_q + VL_W'(1));
      if (last_vec) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_EL; k++) dst_d[k] = dst_q[k];
    for (int i = 0; i < MAX_SUB; i++) begin
      logic [IDX_W-1:0] widx;
      widx = IDX_W'(vidx_q) * IDX_W'(dst_sub) + IDX_W'(i);
      if (SUB_W'(i) < dst_sub && int'(widx) < NUM_EL) dst_d[widx] = lane_val[i];
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      vidx_q <= '0;
      var_q  <= VAR_INT2;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      ill_q  <= ill_d;
      vidx_q <= vidx_d;
      var_q  <= var_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_EL; k++) dst_q[k] <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NUM_EL; k++) dst_q[k] <= dst_d[k];
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_EL; k++) dst_flat[k*ELEM_W +: ELEM_W] = dst_q[k];
  end

  assign variant = var_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign illegal = ill_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q); // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q); // R9
  AST_ILL_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ill_q) |-> done_q); // R3
  AST_BAD_VAR_ILL: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && var_q == VAR_BAD) |-> ill_q); // R6
  AST_IDLE_DST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(dst_flat)); // R2
  AST_VIDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(vidx_q) < MAX_VL)); // R10
endmodule

// File: tb/tb_vec_swizzle_interleaver.sv
module tb_vec_swizzle_interleaver;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         start = 1'b0;
  logic [31:0]  insn = '0;
  logic [2:0]   vl = '0, dsub = 3'd1, ssub = 3'd1;
  logic [7:0]   a_mem [16];
  logic [7:0]   b_mem [16];
  logic [11:0]  s_mem [4];
  logic [127:0] a_flat, b_flat, dst_flat;
  logic [47:0]  s_flat;
  logic [2:0]   variant;
  logic         busy, done, illegal;

  int checks = 0, failures = 0;
  bit cmp_en = 0;

  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < 16; k++) begin
      a_flat[k*8 +: 8] = a_mem[k];
      b_flat[k*8 +: 8] = b_mem[k];
    end
    for (int v = 0; v < 4; v++) s_flat[v*12 +: 12] = s_mem[v];
  end

  vec_swizzle_interleaver dut (
    .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .vl(vl),
    .dst_sub(dsub), .src_sub(ssub), .src_a_flat(a_flat), .src_b_flat(b_flat),
    .sel_flat(s_flat), .dst_flat(dst_flat), .variant(variant),
    .busy(busy), .done(done), .illegal(illegal)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int elem(int k);
    return int'(dst_flat[k*8 +: 8]);
  endfunction

  // Behavioural reference model
  int m_dst [16];
  int m_busy = 0, m_done = 0, m_ill = 0, m_var = 0, m_v = 0;

  function automatic int ref_decode(logic [31:0] w);
    int f3 = int'(w[14:12]);
    if (f3 == 0) return int'(w[26:25]);
    if (f3 == 1) return 4;
    if (f3 == 2) return 5;
    return 7;
  endfunction

  task automatic m_finish(int bad);
    m_busy = 0;
    m_done = 1;
    if (bad != 0) m_ill = 1;
  endtask

  task automatic m_step();
    int vv = int'(vl), ds = int'(dsub), ss = int'(ssub);
    int vals [4];
    bit trap = 0, imm_mode, one;
    if (m_var == 7 || vv > 4 || ds < 1 || ds > 4 || ss < 1 || ss > 4) begin
      m_finish(1);
      return;
    end
    if (vv == 0) begin
      m_finish(0);
      return;
    end
    imm_mode = (m_var == 4 || m_var == 5);
    one = (m_var == 2 || m_var == 3);
    if (!imm_mode)
      for (int b = 3*ds; b < 12; b++) if (s_mem[m_v][b]) trap = 1;
    for (int i = 0; i < ds; i++) begin
      int field, lane;
      if (imm_mode) field = 4 + ((int'(insn[27:20]) >> (2*i)) & 3);
      else          field = (int'(s_mem[m_v]) >> (3*i)) & 7;
      lane = field & 3;
      if (lane >= ss) trap = 1;
      else if (one || (field & 4) != 0) vals[i] = int'(a_mem[m_v*ss + lane]);
      else                              vals[i] = int'(b_mem[m_v*ss + lane]);
    end
    if (trap) begin
      m_finish(1);
      return;
    end
    for (int i = 0; i < ds; i++) m_dst[m_v*ds + i] = vals[i];
    m_v++;
    if (m_v >= vv) m_finish(0);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ill = 0; m_var = 0; m_v = 0;
      for (int k = 0; k < 16; k++) m_dst[k] = 0;
    end else begin
      m_done = 0;
      if (m_busy == 0) begin
        if (start) begin
          m_busy = 1; m_v = 0; m_ill = 0; m_var = ref_decode(insn);
        end
      end else begin
        m_step();
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      int bad_k = -1;
      for (int k = 0; k < 16; k++) if (bad_k < 0 && elem(k) != m_dst[k]) bad_k = k;
      if (bad_k < 0) chk("R2 dst vs model", 0, 0);
      else chk("R2 dst vs model", elem(bad_k), m_dst[bad_k]);
      chk("R9 done vs model", int'(done), m_done);
      chk("R9 busy vs model", int'(busy), m_busy);
      chk("R3 illegal vs model", int'(illegal), m_ill);
      chk("R5 variant vs model", int'(variant), m_var);
    end
  end

  task automatic run();
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (done) return;
    end
    chk("R9 done watchdog", 0, 1);
  endtask

  task automatic setup(logic [31:0] w, int v, int d, int s);
    @(posedge clk); #2;
    insn = w; vl = 3'(v); dsub = 3'(d); ssub = 3'(s);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL R9 global watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) begin
      a_mem[k] = 8'(8'h10 + k);
      b_mem[k] = 8'(8'h80 + k);
    end
    for (int v = 0; v < 4; v++) s_mem[v] = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cmp_en = 1;
    @(negedge clk);
    chk("R11 reset dst", elem(0), 0);
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset illegal", int'(illegal), 0);
    chk("R11 reset variant", int'(variant), 0);

    // Two-source integer, full sub-vectors
    setup(32'h0, 2, 4, 4);
    s_mem[0] = 12'd1372;
    s_mem[1] = 12'd7;
    run();
    chk("R1 lane from second source", elem(1), 8'h83);
    chk("R1 lane from first source", elem(2), 8'h11);
    chk("R2 vector 1 read index", elem(4), 8'h17);
    chk("R9 done with busy low", int'(busy), 0);
    @(negedge clk);
    chk("R9 done lasts one cycle", int'(done), 0);

    // Differing sub-vector lengths
    setup(32'h0, 3, 2, 3);
    s_mem[0] = 12'd14; s_mem[1] = 12'd20; s_mem[2] = 12'd40;
    run();
    chk("R2 read v*src_sub+lane", elem(3), 8'h85);
    chk("R2 write v*dst_sub+i", elem(5), 8'h17);
    chk("R2 untouched element kept", elem(6), 8'h84);

    // Upper selector bits set in vector 1
    setup(32'h0, 3, 2, 4);
    s_mem[0] = 12'd4; s_mem[1] = 12'd64; s_mem[2] = 12'd4;
    run();
    chk("R3 upper bits trap", int'(illegal), 1);
    chk("R3 earlier vector written", elem(1), 8'h80);
    chk("R3 trapped vector not written", elem(2), 8'h13);

    // Lane index beyond source sub-vector
    setup(32'h0, 1, 1, 2);
    s_mem[0] = 12'd6;
    run();
    chk("R4 lane range trap", int'(illegal), 1);
    chk("R4 no write on trap", elem(0), 8'h10);

    // Single-source integer: bit 2 ignored
    setup(32'h0400_0000, 1, 2, 2);
    s_mem[0] = 12'd1;
    run();
    chk("R5 variant single-source int", int'(variant), 2);
    chk("R7 cleared bit 2 still first source", elem(0), 8'h11);
    chk("R7 lane 1 first source", elem(1), 8'h10);

    // Immediate integer swizzle, selector input ignored
    setup(32'h0630_1000, 2, 4, 4);
    for (int v = 0; v < 4; v++) s_mem[v] = 12'hFFF;
    run();
    chk("R6 variant immediate int", int'(variant), 4);
    chk("R8 x lane", elem(0), 8'h13);
    chk("R8 y lane", elem(1), 8'h10);
    chk("R8 w lane vector 1", elem(7), 8'h15);
    chk("R8 not illegal", int'(illegal), 0);

    // Undecodable funct3
    setup(32'h0000_3000, 2, 4, 4);
    run();
    chk("R6 invalid variant code", int'(variant), 7);
    chk("R6 invalid sets illegal", int'(illegal), 1);
    chk("R6 invalid no write", elem(0), 8'h13);

    // Floating immediate, zero vectors
    setup(32'h0000_2000, 0, 4, 4);
    run();
    chk("R6 variant immediate fp", int'(variant), 5);
    chk("R9 vl zero not illegal", int'(illegal), 0);
    chk("R9 vl zero no write", elem(0), 8'h13);

    // Floating two-source decode
    setup(32'h0200_0000, 1, 1, 1);
    s_mem[0] = 12'd4;
    run();
    chk("R5 variant two-source fp", int'(variant), 1);
    chk("R1 fp two-source first source", elem(0), 8'h10);

    // Out-of-range configuration
    setup(32'h0, 5, 4, 4);
    run();
    chk("R10 vl too large", int'(illegal), 1);
    setup(32'h0, 1, 0, 4);
    run();
    chk("R10 zero dst_sub", int'(illegal), 1);
    chk("R10 no write", elem(0), 8'h10);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule